// File: doc/BRIEF.md
# Control-Port Write Master

This block writes one word into a PHY's indirect control register space through a single-acknowledge handshake port. The user presents a 16-bit register address and a 16-bit value with a one-cycle request. The master then runs three handshake phases in a fixed order. First it captures the address, then it captures the data, and finally it issues the write command.

Every phase is a full four-phase exchange. The master puts the phase's word on the data-in bus one cycle before raising that phase's command line. It then waits for the acknowledge to rise, drops the command while keeping the word on the bus, and waits for the acknowledge to fall. Each of the two waits has its own cycle-count limit. If a wait runs past its limit, the transfer stops with an error and no later phase is started. A three-bit code reports which phase failed and on which edge. The acknowledge passes through a two-flop synchronizer before the master uses it.

Top module: `crport_wr_master`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`, `done_o`, `err_o`, all three command lines and `cr_din_o` are low (zero).
- R2: A transfer raises the command lines in this order: `cr_cap_addr_o` with `cr_din_o` equal to the address, then `cr_cap_data_o` with `cr_din_o` equal to the data, then `cr_write_o` with `cr_din_o` equal to the data.
- R3: `cr_din_o` holds its phase word for the cycle before the command line rises and for every cycle the command line is high.
- R4: At most one command line is high in any cycle.
- R5: A phase advances only after the acknowledge has risen and then fallen. The next command line never rises while the acknowledge is still high.
- R6: The acknowledge is synchronized by two flops. If the acknowledge rises D cycles after the command line is first seen high, the command line stays high for exactly D+3 cycles.
- R7: If the synchronized acknowledge has not risen by the end of TIMEOUT_CYC cycles of command-high waiting, the command line drops after exactly TIMEOUT_CYC cycles and the transfer aborts. An acknowledge that arrives in the last counted cycle still counts as success.
- R8: If the acknowledge has not fallen within TIMEOUT_CYC cycles after the command drops, the transfer aborts.
- R9: After an abort, no later phase's command line is raised.
- R10: `done_o` pulses high for one cycle when a transfer ends, and `busy_o` is already low in that cycle. `err_o` is high together with `done_o` only on an abort. `err_code_o` = {phase, edge} is held until the next request is accepted, with phase 0 = address, 1 = data, 2 = write, and edge 0 = rising wait, 1 = falling wait.
- R11: A request raised while `busy_o` is high is ignored. The transfer in progress keeps its address and data, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a write; accepted only when idle |
| addr_i | input | WORD_W | Register address, latched on acceptance |
| data_i | input | WORD_W | Register value, latched on acceptance |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Abort flag, valid with done_o |
| err_code_o | output | 3 | {phase, edge} of the failed wait |
| cr_din_o | output | WORD_W | Data-in bus to the PHY port |
| cr_cap_addr_o | output | 1 | Address-capture command |
| cr_cap_data_o | output | 1 | Data-capture command |
| cr_write_o | output | 1 | Write command |
| cr_ack_i | input | 1 | Acknowledge from the PHY, asynchronous |

## Verification
A behavioural PHY model answers each phase with programmable rise and fall delays. It can also refuse to raise, or refuse to drop, the acknowledge in a chosen phase. Short and long delays with all-ones and all-zeros words show that the right word goes with the right command, and that the command-high length follows the acknowledge through the synchronizer. A delay that lands exactly on the limit separates a late success from a timeout. Hangs placed in different phases and on both edges separate the four reported codes and show that later phases stay silent. A second request during a busy transfer shows that the latched operands are not overwritten.

// File: rtl/crport_pkg.sv
package crport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_WAIT_LO = 2'd3
  } cr_state_e;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2
  } cr_phase_e;

  localparam int unsigned NUM_PHASES = 3;
  localparam logic EDGE_RISE = 1'b0;
  localparam logic EDGE_FALL = 1'b1;
endpackage

// File: rtl/crport_sync.sv
module crport_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/crport_wait_timer.sv
module crport_wait_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (en_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // true in the LIMIT-th cycle of a wait
  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/crport_wr_master.sv
module crport_wr_master
  import crport_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic [WORD_W-1:0] cr_din_o,
  output logic              cr_cap_addr_o,
  output logic              cr_cap_data_o,
  output logic              cr_write_o,
  input  logic              cr_ack_i
);
  cr_state_e         state_q, state_d;
  cr_phase_e         phase_q, phase_d;
  logic [WORD_W-1:0] addr_q, data_q;
  logic              done_q, err_q;
  logic [2:0]        code_q;
  logic              ack_s, expired;
  logic              finish, fail, fail_edge;
  logic [NUM_PHASES-1:0] cmd_vec;

  crport_sync #(.STAGES(2)) i_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cr_ack_i),
    .q_o    (ack_s)
  );

  crport_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q != state_d),
    .en_i      (state_q == ST_WAIT_HI || state_q == ST_WAIT_LO),
    .expired_o (expired)
  );

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    finish    = 1'b0;
    fail      = 1'b0;
    fail_edge = EDGE_RISE;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_SETUP;
        phase_d = PH_ADDR;
      end
      ST_SETUP: state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (ack_s) state_d = ST_WAIT_LO;
        else if (expired) begin
          fail    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_LO: begin
        if (!ack_s) begin
          if (phase_q == PH_WRITE) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            phase_d = cr_phase_e'(phase_q + 2'd1);
            state_d = ST_SETUP;
          end
        end else if (expired) begin
          fail      = 1'b1;
          fail_edge = EDGE_FALL;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= finish | fail;
      err_q   <= fail;
      if (state_q == ST_IDLE && req_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
        code_q <= '0;
      end else if (fail) begin
        code_q <= {phase_q, fail_edge};
      end
    end
  end

  // one command line per phase, high only while waiting for the rising ack
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_cmd
    assign cmd_vec[g] = (state_q == ST_WAIT_HI) && (phase_q == 2'(g));
  end

  assign cr_cap_addr_o = cmd_vec[PH_ADDR];
  assign cr_cap_data_o = cmd_vec[PH_DATA];
  assign cr_write_o    = cmd_vec[PH_WRITE];
  assign busy_o        = (state_q != ST_IDLE);
  assign cr_din_o      = !busy_o ? '0 : (phase_q == PH_ADDR) ? addr_q : data_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_code_o    = code_q;
endmodule

// File: rtl/crport_wr_master_chk.sv
module crport_wr_master_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [2:0]        err_code_o,
  input logic [WORD_W-1:0] cr_din_o,
  input logic              cr_cap_addr_o,
  input logic              cr_cap_data_o,
  input logic              cr_write_o
);
  logic cmd_any;
  assign cmd_any = cr_cap_addr_o | cr_cap_data_o | cr_write_o;

  assert_cmd_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cr_write_o, cr_cap_data_o, cr_cap_addr_o}));

  assert_din_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_any |-> $stable(cr_din_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cmd_any && cr_din_o == '0));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_done_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_code_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> $stable(err_code_o));
endmodule

bind crport_wr_master crport_wr_master_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .err_code_o    (err_code_o),
  .cr_din_o      (cr_din_o),
  .cr_cap_addr_o (cr_cap_addr_o),
  .cr_cap_data_o (cr_cap_data_o),
  .cr_write_o    (cr_write_o)
);

// File: tb/test_crport_wr_master.sv
module test_crport_wr_master;
  localparam int T = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0, data_i = '0;
  logic        busy_o, done_o, err_o;
  logic [2:0]  err_code_o;
  logic [15:0] cr_din_o;
  logic        cr_cap_addr_o, cr_cap_data_o, cr_write_o;
  logic        cr_ack_i = 1'b0;

  int n_checks = 0, n_errors = 0, done_cnt = 0;
  logic [19:0] exp_q[$];

  int rise_dly = 1, fall_dly = 1, hang_rise = -1, hang_fall = -1;
  int hi_cnt = 0, lo_cnt = 0, cur_ph = 0;
  logic [2:0]  prev_cmd = '0;
  logic [15:0] din_at = '0;
  logic        done_prev = 1'b0;

  always #5 clk_i = ~clk_i;

  crport_wr_master #(.WORD_W(16), .TIMEOUT_CYC(T)) i_crport_wr_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
    .cr_din_o(cr_din_o), .cr_cap_addr_o(cr_cap_addr_o), .cr_cap_data_o(cr_cap_data_o),
    .cr_write_o(cr_write_o), .cr_ack_i(cr_ack_i)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // PHY model: captures, programmable ack delays, optional hangs
  always @(posedge clk_i) begin
    logic [2:0] c;
    logic [19:0] e;
    c = {cr_write_o, cr_cap_data_o, cr_cap_addr_o};
    if (!rst_ni) begin
      cr_ack_i <= 1'b0;
      prev_cmd = '0;
      hi_cnt = 0;
      lo_cnt = 0;
    end else begin
      if (c != 3'b000) begin
        lo_cnt = 0;
        if (prev_cmd == 3'b000) begin
          hi_cnt = 1;
          cur_ph = c[0] ? 0 : (c[1] ? 1 : 2);
          din_at = cr_din_o;
          // R2 / R5 / R9: capture must match next expected item
          if (exp_q.size() == 0) check(1'b0, "R9 unexpected command", {cur_ph[1:0], cr_din_o}, 0);
          else begin
            e = exp_q.pop_front();
            check(e == {cur_ph[1:0], 2'b00, cr_din_o}, "R2 capture order/word",
                  {cur_ph[1:0], 2'b00, cr_din_o}, e);
          end
        end else begin
          hi_cnt++;
          check(cr_din_o == din_at, "R3 data-in held", cr_din_o, din_at);
        end
        if (hi_cnt >= rise_dly && cur_ph != hang_rise) cr_ack_i <= 1'b1;
      end else begin
        if (prev_cmd != 3'b000) begin
          if (cur_ph == hang_rise) check(hi_cnt == T, "R7 command-high length on timeout", hi_cnt, T);
          else check(hi_cnt == rise_dly + 3, "R6 command-high length", hi_cnt, rise_dly + 3);
        end
        if (cr_ack_i) begin
          lo_cnt++;
          if (lo_cnt >= fall_dly && cur_ph != hang_fall) cr_ack_i <= 1'b0;
        end
      end
      prev_cmd = c;
    end
  end

  // monitor: results against scoreboard
  always @(negedge clk_i) begin
    logic [19:0] e;
    if (rst_ni) begin
      if (done_o) begin
        if (done_prev) check(1'b0, "R10 done longer than one cycle", 1, 0);
        check(!busy_o, "R10 busy low with done", busy_o, 0);
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(e == {2'b11, 14'd0, err_o, err_code_o}, "R7 R8 R10 result",
                {2'b11, 14'd0, err_o, err_code_o}, e);
        end
        done_cnt++;
      end
      done_prev = done_o;
    end
  end

  task automatic run(input logic [15:0] a, input logic [15:0] d, input int rd, input int fd,
                     input int hr, input int hf, input bit poke);
    int n0;
    int last;
    logic       er;
    logic [2:0] cd;
    n0 = done_cnt;
    rise_dly = rd; fall_dly = fd; hang_rise = hr; hang_fall = hf;
    last = (hr >= 0) ? hr : ((hf >= 0) ? hf : 2);
    for (int p = 0; p <= last; p++)
      exp_q.push_back({p[1:0], 2'b00, (p == 0) ? a : d});
    er = (hr >= 0) || (hf >= 0);
    cd = (hr >= 0) ? {hr[1:0], 1'b0} : ((hf >= 0) ? {hf[1:0], 1'b1} : 3'd0);
    exp_q.push_back({2'b11, 14'd0, er, cd});
    @(negedge clk_i);
    req_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    check(busy_o, "R10 busy after accept", busy_o, 1);
    if (poke) begin
      repeat (4) @(negedge clk_i);
      req_i = 1'b1; addr_i = ~a; data_i = ~d;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    wait (done_cnt != n0);
    repeat (3) @(negedge clk_i);
    check(!busy_o, "R11 no further transfer", busy_o, 0);
    check(exp_q.size() == 0, "R9 all expected items seen", exp_q.size(), 0);
    check(err_code_o == cd, "R10 code held", err_code_o, cd);
    hang_rise = -1; hang_fall = -1;
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !err_o, "R1 reset status", {busy_o, done_o, err_o}, 0);
    check({cr_write_o, cr_cap_data_o, cr_cap_addr_o} == 0 && cr_din_o == 0, "R1 reset PHY side",
          {cr_write_o, cr_cap_data_o, cr_cap_addr_o, cr_din_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && cr_din_o == 0, "R1 idle after reset", {busy_o, cr_din_o}, 0);
    run(16'h1234, 16'hBEEF, 1, 1, -1, -1, 0);   // R2 R5 R6 basic
    run(16'hFFFF, 16'h0000, 5, 3, -1, -1, 0);   // R2 R6 longer delays
    run(16'h00A5, 16'h5A00, T - 3, 2, -1, -1, 0); // R7 ack in last counted cycle
    run(16'h0101, 16'h0202, 2, 1, 0, -1, 0);    // R7 R9 address rise hang
    run(16'h0303, 16'h0404, 1, 2, 2, -1, 0);    // R7 write rise hang
    run(16'h0505, 16'h0606, 2, 1, -1, 1, 0);    // R8 R9 data fall hang
    run(16'h0707, 16'h0808, 3, 1, -1, 2, 0);    // R8 write fall hang
    run(16'hC0DE, 16'hF00D, 2, 2, -1, -1, 1);   // R11 request while busy
    run(16'h8001, 16'h7FFE, 1, 4, -1, -1, 0);   // recovery after aborts
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "R1 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule